// File: doc/BRIEF.md
# Dual-Phase Interval Timer with Watchdog Reset

This peripheral holds two independent 32-bit down-counting timers behind a small register bus. The bus has an address, a write strobe, write data and combinational read data. Each timer runs in two phases. It first counts a "high" interval, then a "low" interval, and then starts over. One full period therefore lasts the sum of the two programmed counts. A period can be as short as two clock cycles or as long as about 2·2^32 cycles. Each timer marks the end of every period with a one-cycle event pulse. Timer 1 is meant to drive the system tick interrupt.

Timer 0 can be turned into a watchdog. To do so, software writes its high-interval register with the marker 0xFF in the low byte and a count in bits 31:8. Once enabled, a watchdog that expires raises a reset request. The request stays asserted until the block is reset. Software writes the count registers only while the timer is stopped. Setting the enable bit starts a fresh count from the stored values.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset every register reads 0, both timers are stopped and `tick_irq1`, `tick_irq0` and `wdog_req` are low.
- R2: Registers are at byte offsets 0x00 control (bit 0 = timer 0 run, bit 1 = timer 1 run, bits 31:2 read 0), 0x04 timer 1 high count, 0x08 timer 0 high count, 0x0C timer 1 low count and 0x10 timer 0 low count. Each register reads back the last value written to it. Any other address, including one with bits 1:0 nonzero, reads 0 and writes nothing.
- R3: If control bit 1 is set with high count H and low count L, then `tick_irq1` first goes high at the H+L-th rising edge after the edge that accepts the control write.
- R4: While a timer stays enabled, its events repeat every H+L cycles.
- R5: A count of 0 in either phase behaves as a count of 1, so the shortest period is 2 cycles.
- R6: Each event is a pulse exactly one cycle wide.
- R7: Clearing a run bit stops that timer. From the second edge after the clearing write, no event appears. Setting the bit again restarts from the high phase with the stored counts.
- R8: A write to a count register of a timer whose run bit is set is ignored, and the register keeps its old value.
- R9: Timer 0, controlled by bit 0 with counts at 0x08 and 0x10, pulses `tick_irq0` with the same timing as timer 1.
- R10: If bits 7:0 of the timer 0 high-count register equal 0xFF, timer 0 is a watchdog with count N = bits 31:8 (0 behaves as 1). `wdog_req` rises at the N+1-th edge after the enabling write, and `tick_irq0` stays low in this mode.
- R11: Once set, `wdog_req` stays high even if timer 0 is stopped. Only reset clears it.
- R12: The two timers run independently when enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_irq1 | output | 1 | Timer 1 period-end pulse |
| tick_irq0 | output | 1 | Timer 0 period-end pulse (normal mode only) |
| wdog_req | output | 1 | Sticky reset request from the watchdog |

## Verification
The hardest state to reach from the ports is a configuration change that lands while a timer is running. Two cases matter: a count write that must be discarded, and a disable followed by a re-enable that must restart the phase sequence rather than resume it. The stimulus reaches these by writing a count register in the middle of a run and then reading it back. It also stops timers part-way through a period and re-arms them with new random counts. Random high and low counts, including zeros, are mixed with a run of both timers at once. The watchdog expiry is placed last, because its request can be cleared only by reset.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int unsigned DPT_W    = 32;
  localparam int unsigned DPT_AW   = 5;
  localparam logic [7:0]  WDOG_TAG = 8'hFF;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_HI1, SEL_HI0, SEL_LO1, SEL_LO0, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [DPT_AW-1:0] a);
    case (a)
      5'h00:   return SEL_CTRL;
      5'h04:   return SEL_HI1;
      5'h08:   return SEL_HI0;
      5'h0C:   return SEL_LO1;
      5'h10:   return SEL_LO0;
      default: return SEL_NONE;
    endcase
  endfunction

  // A zero count still occupies one cycle.
  function automatic logic [DPT_W-1:0] eff_count(input logic [DPT_W-1:0] v);
    return (v == '0) ? {{(DPT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  function automatic logic is_wdog_tag(input logic [DPT_W-1:0] v);
    return v[7:0] == WDOG_TAG;
  endfunction

  function automatic logic [DPT_W-1:0] wdog_count(input logic [DPT_W-1:0] v);
    return {8'h00, v[DPT_W-1:8]};
  endfunction

endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned CNT_W   = DPT_W,
  parameter int unsigned ADDR_W  = DPT_AW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  input  logic [CNT_W-1:0]               wdata,
  output logic [CNT_W-1:0]               rdata,
  output logic [NUM_TMR-1:0]             run_en,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  hi_q,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  lo_q
);

  reg_sel_e sel;
  assign sel = decode_addr(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: run_en <= wdata[NUM_TMR-1:0];
        SEL_HI1:  if (!run_en[1]) hi_q[1] <= wdata;
        SEL_HI0:  if (!run_en[0]) hi_q[0] <= wdata;
        SEL_LO1:  if (!run_en[1]) lo_q[1] <= wdata;
        SEL_LO0:  if (!run_en[0]) lo_q[0] <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = {{(CNT_W-NUM_TMR){1'b0}}, run_en};
      SEL_HI1:  rdata = hi_q[1];
      SEL_HI0:  rdata = hi_q[0];
      SEL_LO1:  rdata = lo_q[1];
      SEL_LO0:  rdata = lo_q[0];
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/dpt_phase_ctr.sv
module dpt_phase_ctr
  import dpt_pkg::*;
#(
  parameter int unsigned CNT_W = DPT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             single,
  input  logic [CNT_W-1:0] hi_val,
  input  logic [CNT_W-1:0] lo_val,
  output logic             running,
  output logic             evt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == ONE);
  assign evt    = running && at_end && (phase == PH_LOW || single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_HIGH;
      cnt     <= ONE;
    end else if (!en) begin
      running <= 1'b0;
      phase   <= PH_HIGH;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= PH_HIGH;
      cnt     <= eff_count(hi_val);
    end else if (at_end) begin
      if (phase == PH_HIGH && !single) begin
        phase <= PH_LOW;
        cnt   <= eff_count(lo_val);
      end else begin
        phase <= PH_HIGH;
        cnt   <= eff_count(hi_val);
      end
    end else begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/dpt_wdog_latch.sv
module dpt_wdog_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic expire,
  output logic req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else if (armed && expire) req <= 1'b1;
  end

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int unsigned CNT_W  = DPT_W,
  parameter int unsigned ADDR_W = DPT_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              tick_irq1,
  output logic              tick_irq0,
  output logic              wdog_req
);

  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned WDOG_IDX = 0;

  logic [NUM_TMR-1:0]            run_en;
  logic [NUM_TMR-1:0][CNT_W-1:0] hi_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] lo_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] hi_sel;
  logic [NUM_TMR-1:0]            single_ph;
  logic [NUM_TMR-1:0]            running;
  logic [NUM_TMR-1:0]            evt;
  logic                          wdog_mode;

  assign wdog_mode = is_wdog_tag(hi_q[WDOG_IDX]);

  dpt_regs #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .run_en(run_en), .hi_q(hi_q), .lo_q(lo_q)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    if (i == WDOG_IDX) begin : g_wd
      assign single_ph[i] = wdog_mode;
      assign hi_sel[i]    = wdog_mode ? wdog_count(hi_q[i]) : hi_q[i];
    end else begin : g_plain
      assign single_ph[i] = 1'b0;
      assign hi_sel[i]    = hi_q[i];
    end

    dpt_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .en(run_en[i]), .single(single_ph[i]),
      .hi_val(hi_sel[i]), .lo_val(lo_q[i]),
      .running(running[i]), .evt(evt[i])
    );
  end

  dpt_wdog_latch u_wdog (
    .clk(clk), .rst_n(rst_n), .armed(wdog_mode),
    .expire(evt[WDOG_IDX]), .req(wdog_req)
  );

  assign tick_irq1 = evt[1];
  assign tick_irq0 = evt[WDOG_IDX] && !wdog_mode;

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      bus_addr,
  input logic            bus_we,
  input logic            tick_irq1,
  input logic            tick_irq0,
  input logic            wdog_req,
  input logic            wdog_mode,
  input logic [1:0]      run_en,
  input logic [1:0][31:0] hi_q,
  input logic [1:0][31:0] lo_q
);

  a_r6_irq1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq1 |=> !tick_irq1);

  a_r6_irq0_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq0 |=> !tick_irq0);

  a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en[1] && !$past(run_en[1])) |-> !tick_irq1);

  a_r8_hold_high_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h04 && run_en[1]) |=> $stable(hi_q[1]));

  a_r8_hold_low_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h0C && run_en[1]) |=> $stable(lo_q[1]));

  a_r10_no_tick_as_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_mode |-> !tick_irq0);

  a_r10_req_needs_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_req) |-> $past(wdog_mode));

  a_r11_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_req |=> wdog_req);

endmodule

bind dual_phase_timer dpt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .tick_irq1(tick_irq1), .tick_irq0(tick_irq0), .wdog_req(wdog_req),
  .wdog_mode(wdog_mode), .run_en(run_en), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/dual_phase_timer_bench.sv
module dual_phase_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq1, tick_irq0, wdog_req;

  always #10 clk = ~clk;

  dual_phase_timer u_dual_phase_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq1(tick_irq1), .tick_irq0(tick_irq0), .wdog_req(wdog_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [1:0] ctrl_sh = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL run watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic longint eff(input longint v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic longint period_of(input longint hi, input longint lo);
    return eff(hi) + eff(lo);
  endfunction

  function automatic longint wdog_edges(input logic [31:0] v);
    return eff(longint'(v >> 8)) + 1;
  endfunction

  function automatic logic [4:0] hi_addr(input int idx);
    return (idx == 1) ? 5'h04 : 5'h08;
  endfunction

  function automatic logic [4:0] lo_addr(input int idx);
    return (idx == 1) ? 5'h0C : 5'h10;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(input logic [1:0] v);
    ctrl_sh = v;
    wr(5'h00, {30'd0, v});
  endtask

  task automatic wait_evt(input int idx, input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if ((idx == 1) ? tick_irq1 : tick_irq0) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic arm(input int idx, input logic [31:0] hi, input logic [31:0] lo);
    logic [1:0] m;
    m = ctrl_sh;
    m[idx] = 1'b0;
    set_ctrl(m);
    wr(hi_addr(idx), hi);
    wr(lo_addr(idx), lo);
    m[idx] = 1'b1;
    set_ctrl(m);
  endtask

  initial begin
    logic [31:0] d;
    int k, k1, k0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq1 low", tick_irq1, 0);
    check("R1 irq0 low", tick_irq0, 0);
    check("R1 wdog low", wdog_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h00, d); check("R1 ctrl reads 0", d, 0);
    rd(5'h04, d); check("R1 hi1 reads 0", d, 0);
    rd(5'h10, d); check("R1 lo0 reads 0", d, 0);

    // R2: readback and decoding
    wr(5'h04, 32'hDEAD_0001); wr(5'h08, 32'h1234_5600);
    wr(5'h0C, 32'hCAFE_0002); wr(5'h10, 32'h0000_0FF0);
    rd(5'h04, d); check("R2 hi1", d, 32'hDEAD_0001);
    rd(5'h08, d); check("R2 hi0", d, 32'h1234_5600);
    rd(5'h0C, d); check("R2 lo1", d, 32'hCAFE_0002);
    rd(5'h10, d); check("R2 lo0", d, 32'h0000_0FF0);
    rd(5'h14, d); check("R2 unmapped", d, 0);
    wr(5'h06, 32'h5555_5555);
    rd(5'h04, d); check("R2 misaligned write ignored", d, 32'hDEAD_0001);
    rd(5'h06, d); check("R2 misaligned read", d, 0);

    // R3 R4 R6 directed on timer 1
    arm(1, 32'd4, 32'd3);
    rd(5'h00, d); check("R2 ctrl readback", d, 2);
    wait_evt(1, 200, k); check("R3 first period", k, 7);
    wait_evt(1, 200, k); check("R4 repeat period", k, 7);
    @(negedge clk); check("R6 pulse width", tick_irq1, 0);

    // R8: writes while running are dropped
    wr(5'h04, 32'd99); wr(5'h0C, 32'd77);
    rd(5'h04, d); check("R8 hi1 kept", d, 4);
    rd(5'h0C, d); check("R8 lo1 kept", d, 3);

    // R7: stop, stay quiet, restart with fresh values
    set_ctrl(2'b00);
    k = -1;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_irq1) k = i;
    end
    check("R7 silent when stopped", k, -1);
    arm(1, 32'd10, 32'd2);
    wait_evt(1, 200, k); check("R7 restart period", k, 12);

    // R5: zero counts
    arm(1, 32'd0, 32'd0);
    wait_evt(1, 200, k); check("R5 zero/zero first", k, 2);
    wait_evt(1, 200, k); check("R5 zero/zero repeat", k, 2);
    @(negedge clk); check("R6 pulse at period 2", tick_irq1, 0);
    arm(1, 32'd0, 32'd7);
    wait_evt(1, 200, k); check("R5 zero high", k, 8);
    set_ctrl(2'b00);

    // Random mix, both timers (R3 R4 R9)
    for (int it = 0; it < 12; it++) begin
      int idx;
      logic [31:0] hi, lo;
      idx = int'($urandom % 2);
      hi  = $urandom % 24;
      lo  = $urandom % 24;
      arm(idx, hi, lo);
      wait_evt(idx, 500, k);
      check(idx == 1 ? "R3 random first" : "R9 random first", k, period_of(hi, lo));
      wait_evt(idx, 500, k);
      check(idx == 1 ? "R4 random repeat" : "R9 random repeat", k, period_of(hi, lo));
      set_ctrl(2'b00);
    end

    // R12: both at once
    wr(5'h04, 32'd3); wr(5'h0C, 32'd4);
    wr(5'h08, 32'd5); wr(5'h10, 32'd6);
    set_ctrl(2'b11);
    k1 = -1; k0 = -1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (tick_irq1 && k1 < 0) k1 = i;
      if (tick_irq0 && k0 < 0) k0 = i;
    end
    check("R12 timer1 period", k1, 7);
    check("R12 timer0 period", k0, 11);
    set_ctrl(2'b00);

    // R10: watchdog mode
    d = (32'd10 << 8) | 32'hFF;
    wr(5'h08, d);
    set_ctrl(2'b01);
    k = -1; k0 = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (tick_irq0) k0 = 1;
      if (wdog_req && k < 0) k = i;
    end
    check("R10 watchdog expiry edge", k, wdog_edges(d));
    check("R10 no tick in watchdog", k0, 0);

    // R11: sticky until reset
    set_ctrl(2'b00);
    repeat (20) @(negedge clk);
    check("R11 request held", wdog_req, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset clears request", wdog_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h00, d); check("R1 ctrl after reset", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule